// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Same-Address Collision Reporting

This block is a true dual-port synchronous memory. Both ports share one clock. Each port has an active-low enable, an active-low write enable, a word address, write data, an active-low write mask and a registered read output. Either port can read or write any word in any cycle. A port's read data appears one clock after the read is accepted.

When both ports are enabled on the same address at one rising edge, the block sorts the access into one of three cases:

- **Read/read** is harmless. Both ports return the stored word.
- **Write/read**, in either port order, lets the write finish. The reading port's result is spoiled.
- **Write/write** leaves the word undefined.

An undefined word is tracked by a per-word invalid bit. Each port has a one-cycle collision flag, which it raises alongside any spoiled or untrustworthy result. A later full-word write repairs the word.

The write mask works in one of two ways, chosen by a parameter. In bit mode there is one mask bit per data bit. In byte mode there is one mask bit per 8-bit lane, which suits byte-enable buses.

Top module: `dp_ram_clash`

## Requirements
- R1: An enabled read (enable low, write enable high) accepted at a rising edge places the addressed word on that port's data output right after that edge. The other port's write in the same cycle to a different address does not disturb it.
- R2: A port's data output holds its value after any edge where that port is disabled or writing. Its collision flag is low after any edge where the port is disabled, and it stays high for one cycle only unless a new collision occurs.
- R3: In bit mode (BYTE_MODE=0) the mask port has DATA_W bits. Data bit i is written only when the write enable is low and mask bit i is low. Every other bit of the word keeps its old value.
- R4: In byte mode (BYTE_MODE=1) the mask port has DATA_W/8 bits. Mask bit k (active low) gates data bits 8k to 8k+7. DATA_W must be a multiple of 8.
- R5: With every mask bit low, a write replaces the whole word.
- R6: Accesses by the two ports to different addresses in one cycle never interact, and neither port flags.
- R7: Two reads of the same valid word in one cycle both return the stored word, and neither port flags.
- R8: On a same-address write/read in either port order, the write is stored normally. The reading port's flag is high after that edge and its data is unspecified. The writing port's flag stays low.
- R9: On a same-address write/write, both flags are high after that edge and the word is marked invalid.
- R10: A read of an invalid word raises that port's flag after the edge. Its data is unspecified.
- R11: A write with every bit enabled that is not a write/write clash clears the word's invalid mark. A partial write leaves the mark set.
- R12: While reset is low at a rising edge, both data outputs go to zero, both flags go low and every word becomes valid. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en_n | input | 1 | Port A enable, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_wmask_n | input | MASK_W | Port A write mask, active low (per bit or per byte) |
| a_dout | output | DATA_W | Port A registered read data |
| a_clash | output | 1 | Port A collision / untrusted-data flag |
| b_en_n | input | 1 | Port B enable, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_wmask_n | input | MASK_W | Port B write mask, active low (per bit or per byte) |
| b_dout | output | DATA_W | Port B registered read data |
| b_clash | output | 1 | Port B collision / untrusted-data flag |

## Verification
A wrong invalid bit stays hidden until the affected word is next read. That read shows either a missing flag or a spurious flag one clock later. The bench therefore reads back every clashed word, both before and after partial and full repair writes.

A misclassified collision shows on the very next edge. The wrong port flags, or a write that should have landed is missing from the following read.

Mask errors show only in the bits outside the enabled lanes. For this reason the bench uses uneven masks in both modes and checks the whole word on read-back.

// File: rtl/dp_ram_clash_pkg.sv
// Package: shared types for the collision-reporting dual-port RAM.
// Assumes: nothing; holds only the collision classification.
package dp_ram_clash_pkg;

    // Outcome class of one cycle's pair of port accesses
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,  // no same-address pair
        CLS_RR   = 2'd1,  // both read the same word
        CLS_WR   = 2'd2,  // one writes, the other reads the same word
        CLS_WW   = 2'd3   // both write the same word
    } clash_cls_e;

endpackage

// File: rtl/dp_ram_mask_expand.sv
// Module: dp_ram_mask_expand
// Turns one port's active-low write mask into an active-high per-bit
// enable. In byte mode each mask bit drives a whole 8-bit lane.
// Assumes: DATA_W is a multiple of 8 when BYTE_MODE is 1.
module dp_ram_mask_expand #(
    parameter int DATA_W    = 32,
    parameter bit BYTE_MODE = 1'b0,
    localparam int MASK_W   = BYTE_MODE ? DATA_W / 8 : DATA_W
) (
    input  logic [MASK_W-1:0] mask_n,
    output logic [DATA_W-1:0] bit_en,
    output logic              all_en
);

    generate
        if (BYTE_MODE) begin : g_byte
            for (genvar k = 0; k < MASK_W; k++) begin : g_lane
                // replicate one lane enable over its eight data bits
                assign bit_en[8*k +: 8] = {8{~mask_n[k]}};
            end
        end else begin : g_bit
            // one enable per data bit
            assign bit_en = ~mask_n;
        end
    endgenerate

    // full-word write indicator used to repair invalid words
    assign all_en = &bit_en;

endmodule

// File: rtl/dp_ram_clash_detect.sv
// Module: dp_ram_clash_detect
// Decodes each port's request and classifies a same-address pair as
// read/read, write/read or write/write.
// Assumes: both ports are sampled on the same clock edge.
module dp_ram_clash_detect
    import dp_ram_clash_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]             en_n,
    input  logic [1:0]             we_n,
    input  logic [1:0][ADDR_W-1:0] addr,
    output logic [1:0]             rd,
    output logic [1:0]             wr,
    output logic                   ww,
    output logic [1:0]             spoil
);

    clash_cls_e cls;
    logic       same;

    // per-port request decode
    always_comb begin
        for (int p = 0; p < 2; p++) begin
            rd[p] = ~en_n[p] & we_n[p];
            wr[p] = ~en_n[p] & ~we_n[p];
        end
    end

    // both enabled on one address
    assign same = ~en_n[0] & ~en_n[1] & (addr[0] == addr[1]);

    // classify the pair
    always_comb begin
        if (!same)                cls = CLS_NONE;
        else if (wr[0] && wr[1])  cls = CLS_WW;
        else if (wr[0] || wr[1])  cls = CLS_WR;
        else                      cls = CLS_RR;
    end

    // outcome per port
    always_comb begin
        ww = (cls == CLS_WW);
        for (int p = 0; p < 2; p++) begin
            spoil[p] = (cls == CLS_WR) & rd[p];
        end
    end

endmodule

// File: rtl/dp_ram_storage.sv
// Module: dp_ram_storage
// Word array, per-word invalid marks and the two registered read ports.
// Assumes: request decode and classification are done upstream; the
// array itself is not reset, only the marks and output registers are.
module dp_ram_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             rd,
    input  logic [1:0]             wr,
    input  logic                   ww,
    input  logic [1:0]             spoil,
    input  logic [1:0][ADDR_W-1:0] addr,
    input  logic [1:0][DATA_W-1:0] din,
    input  logic [1:0][DATA_W-1:0] bit_en,
    input  logic [1:0]             all_en,
    output logic [1:0][DATA_W-1:0] dout,
    output logic [1:0]             flag
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  inv;

    // masked writes; a write/write clash stores nothing (word is invalid)
    always_ff @(posedge clk) begin
        if (!ww) begin
            for (int p = 0; p < 2; p++) begin
                if (wr[p]) begin
                    mem[addr[p]] <= (mem[addr[p]] & ~bit_en[p]) | (din[p] & bit_en[p]);
                end
            end
        end
    end

    // invalid marks: set on write/write, cleared by a full clean write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv <= '0;
        end else if (ww) begin
            inv[addr[0]] <= 1'b1;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (wr[p] && all_en[p]) begin
                    inv[addr[p]] <= 1'b0;
                end
            end
        end
    end

    // read registers and one-cycle collision flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            flag <= '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                flag[p] <= ww | (rd[p] & (spoil[p] | inv[addr[p]]));
                if (rd[p]) begin
                    dout[p] <= mem[addr[p]];
                end
            end
        end
    end

    // R9
    ww_marks_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ww |=> inv[$past(addr[0])]);

    // R11
    full_write_repairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr[0] && all_en[0] && !ww) |=> !inv[$past(addr[0])]);

    // R10
    invalid_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd[1] && inv[addr[1]]) |=> flag[1]);

endmodule

// File: rtl/dp_ram_clash.sv
// Module: dp_ram_clash (top)
// True dual-port synchronous RAM on one clock with same-address
// collision classification and per-port collision flags.
// Assumes: synchronous active-low reset; MASK_W and ADDR_W are derived
// and must not be overridden.
module dp_ram_clash #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 256,
    parameter bit BYTE_MODE = 1'b0,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int MASK_W   = BYTE_MODE ? DATA_W / 8 : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en_n,
    input  logic              a_we_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    input  logic [MASK_W-1:0] a_wmask_n,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_clash,
    input  logic              b_en_n,
    input  logic              b_we_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    input  logic [MASK_W-1:0] b_wmask_n,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_clash
);

    logic [1:0]             en_n, we_n, rd, wr, spoil, all_en, flag;
    logic                   ww;
    logic [1:0][ADDR_W-1:0] addr;
    logic [1:0][DATA_W-1:0] din, bit_en, dout;
    logic [1:0][MASK_W-1:0] mask_n;

    // gather the two ports into indexed buses
    assign en_n   = {b_en_n, a_en_n};
    assign we_n   = {b_we_n, a_we_n};
    assign addr   = {b_addr, a_addr};
    assign din    = {b_din, a_din};
    assign mask_n = {b_wmask_n, a_wmask_n};

    generate
        for (genvar p = 0; p < 2; p++) begin : g_port
            dp_ram_mask_expand #(
                .DATA_W    (DATA_W),
                .BYTE_MODE (BYTE_MODE)
            ) u_mask (
                .mask_n (mask_n[p]),
                .bit_en (bit_en[p]),
                .all_en (all_en[p])
            );
        end
    endgenerate

    dp_ram_clash_detect #(
        .ADDR_W (ADDR_W)
    ) u_detect (
        .en_n  (en_n),
        .we_n  (we_n),
        .addr  (addr),
        .rd    (rd),
        .wr    (wr),
        .ww    (ww),
        .spoil (spoil)
    );

    dp_ram_storage #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (rd),
        .wr     (wr),
        .ww     (ww),
        .spoil  (spoil),
        .addr   (addr),
        .din    (din),
        .bit_en (bit_en),
        .all_en (all_en),
        .dout   (dout),
        .flag   (flag)
    );

    // split results back to the named ports
    assign a_dout  = dout[0];
    assign b_dout  = dout[1];
    assign a_clash = flag[0];
    assign b_clash = flag[1];

    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en_n || !a_we_n) |=> $stable(a_dout));

    // R2
    b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_en_n |=> !b_clash);

    // R6
    apart_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !b_en_n && !a_we_n && !b_we_n && (a_addr != b_addr))
        |=> (!a_clash && !b_clash));

    // R9
    ww_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !b_en_n && !a_we_n && !b_we_n && (a_addr == b_addr))
        |=> (a_clash && b_clash));

    // R8
    a_wr_b_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !b_en_n && !a_we_n && b_we_n && (a_addr == b_addr))
        |=> (!a_clash && b_clash));

    // R8
    b_wr_a_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !b_en_n && a_we_n && !b_we_n && (a_addr == b_addr))
        |=> (a_clash && !b_clash));

endmodule

// File: tb/dp_ram_clash_tb.sv
`timescale 1ns/1ps
// Bench: drives one bit-mask and one byte-mask instance with the same
// stimulus and compares both against a behavioural model every clock.
module dp_ram_clash_tb;

    localparam int DW    = 32;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst_n;
    logic          en_n   [2];
    logic          we_n   [2];
    logic [AW-1:0] addr   [2];
    logic [DW-1:0] din    [2];
    logic [DW-1:0] mbit_n [2];
    logic [3:0]    mbyte_n[2];
    logic [DW-1:0] dout   [2][2];
    logic          flag   [2][2];

    dp_ram_clash #(.DATA_W(DW), .DEPTH(DEPTH), .BYTE_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(en_n[0]), .a_we_n(we_n[0]), .a_addr(addr[0]), .a_din(din[0]),
        .a_wmask_n(mbit_n[0]), .a_dout(dout[0][0]), .a_clash(flag[0][0]),
        .b_en_n(en_n[1]), .b_we_n(we_n[1]), .b_addr(addr[1]), .b_din(din[1]),
        .b_wmask_n(mbit_n[1]), .b_dout(dout[0][1]), .b_clash(flag[0][1]));

    dp_ram_clash #(.DATA_W(DW), .DEPTH(DEPTH), .BYTE_MODE(1'b1)) u_dut_byte (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(en_n[0]), .a_we_n(we_n[0]), .a_addr(addr[0]), .a_din(din[0]),
        .a_wmask_n(mbyte_n[0]), .a_dout(dout[1][0]), .a_clash(flag[1][0]),
        .b_en_n(en_n[1]), .b_we_n(we_n[1]), .b_addr(addr[1]), .b_din(din[1]),
        .b_wmask_n(mbyte_n[1]), .b_dout(dout[1][1]), .b_clash(flag[1][1]));

    // reference model state: [instance][word] and [instance][port]
    logic [DW-1:0] mm [2][DEPTH];
    bit            mi [2][DEPTH];
    logic [DW-1:0] edout [2][2];
    bit            eflag [2][2];
    bit            eknown[2][2];
    int            n_cmp = 0;
    int            n_bad = 0;
    string         cur_req = "R12";

    function automatic logic [DW-1:0] lanes(input logic [3:0] be);
        logic [DW-1:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = {8{be[k]}};
        return r;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                for (int p = 0; p < 2; p++) begin
                    edout[i][p] = '0; eflag[i][p] = 0; eknown[i][p] = 1;
                end
                for (int w = 0; w < DEPTH; w++) mi[i][w] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic [DW-1:0] bits[2];
                bit rdp[2], wrp[2], same, both_wr, f;
                for (int p = 0; p < 2; p++) begin
                    bits[p] = (i == 0) ? ~mbit_n[p] : lanes(~mbyte_n[p]);
                    rdp[p]  = !en_n[p] && we_n[p];
                    wrp[p]  = !en_n[p] && !we_n[p];
                end
                same    = !en_n[0] && !en_n[1] && (addr[0] == addr[1]);
                both_wr = same && wrp[0] && wrp[1];
                for (int p = 0; p < 2; p++) begin
                    f = both_wr || (rdp[p] && ((same && wrp[1-p]) || mi[i][addr[p]]));
                    eflag[i][p] = f;
                    if (rdp[p]) begin
                        edout[i][p]  = mm[i][addr[p]];
                        eknown[i][p] = !f;
                    end
                end
                if (both_wr) begin
                    mi[i][addr[0]] = 1;
                end else begin
                    for (int p = 0; p < 2; p++) begin
                        if (wrp[p]) begin
                            mm[i][addr[p]] = (mm[i][addr[p]] & ~bits[p]) | (din[p] & bits[p]);
                            if (&bits[p]) mi[i][addr[p]] = 0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 2; p++) begin
                n_cmp++;
                if (flag[i][p] !== eflag[i][p]) begin
                    n_bad++;
                    $display("FAIL %s inst%0d port%0d flag got %0b exp %0b",
                             cur_req, i, p, flag[i][p], eflag[i][p]);
                end
                if (eknown[i][p]) begin
                    n_cmp++;
                    if (dout[i][p] !== edout[i][p]) begin
                        n_bad++;
                        $display("FAIL %s inst%0d port%0d dout got %h exp %h",
                                 cur_req, i, p, dout[i][p], edout[i][p]);
                    end
                end
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic setp(input int p, input bit en, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] mb, input logic [3:0] my);
        en_n[p] = !en; we_n[p] = !we; addr[p] = a; din[p] = d;
        mbit_n[p] = mb; mbyte_n[p] = my;
    endtask

    task automatic wr_full(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        setp(p, 1, 1, a, d, '0, '0);
    endtask

    task automatic rd_at(input int p, input logic [AW-1:0] a);
        setp(p, 1, 0, a, 32'hDEAD_BEEF, '0, '0);   // masks ignored on reads
    endtask

    task automatic off(input int p);
        setp(p, 0, 0, '0, '0, '1, '1);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        off(0); off(1);
        // R12: outputs zero and flags low under reset
        cur_req = "R12";
        repeat (3) cyc();
        rst_n = 1'b1;

        // R5: full-word writes fill the array, A even, B odd
        cur_req = "R5";
        for (int w = 0; w < DEPTH; w += 2) begin
            wr_full(0, w[AW-1:0], 32'h1000_0000 + w);
            wr_full(1, w[AW-1:0] + 1'b1, 32'h2000_0000 + w);
            cyc();
        end
        off(0); off(1); cyc();

        // R1: one-cycle read latency on both ports, R12: all words valid
        cur_req = "R1";
        for (int w = 0; w < 6; w++) begin
            rd_at(0, w[AW-1:0]); rd_at(1, w[AW-1:0] + 8'd40); cyc();
        end

        // R2: output held and flag low while disabled or writing
        cur_req = "R2";
        off(0); off(1); cyc(); cyc();
        wr_full(0, 8'd100, 32'hAAAA_5555); cyc();
        off(0); cyc();

        // R3: per-bit (and matching per-lane) partial write, then read back
        cur_req = "R3";
        setp(0, 1, 1, 8'd3, 32'hFFFF_FFFF, 32'h0F0F_F0F0, 4'b1010); cyc();
        rd_at(0, 8'd3); cyc();
        off(0); cyc();

        // R4: lane-wide mask in byte mode
        cur_req = "R4";
        setp(1, 1, 1, 8'd4, 32'h1234_5678, 32'hFF00_00FF, 4'b0110); cyc();
        rd_at(1, 8'd4); cyc();
        off(1); cyc();

        // R6: different addresses, write beside read, both orders
        cur_req = "R6";
        wr_full(0, 8'd20, 32'hCAFE_0020); rd_at(1, 8'd21); cyc();
        rd_at(0, 8'd21); wr_full(1, 8'd20, 32'hCAFE_1020); cyc();
        rd_at(0, 8'd20); rd_at(1, 8'd20); cyc();

        // R7: read/read of one word
        cur_req = "R7";
        rd_at(0, 8'd30); rd_at(1, 8'd30); cyc();
        off(0); off(1); cyc();

        // R8: write/read both orders, then read back the written data
        cur_req = "R8";
        wr_full(0, 8'd5, 32'h5555_0001); rd_at(1, 8'd5); cyc();
        rd_at(0, 8'd5); rd_at(1, 8'd5); cyc();
        rd_at(0, 8'd6); wr_full(1, 8'd6, 32'h6666_0002); cyc();
        rd_at(0, 8'd6); off(1); cyc();

        // R9: write/write clash flags both ports
        cur_req = "R9";
        wr_full(0, 8'd9, 32'h9999_0000); wr_full(1, 8'd9, 32'h0000_9999); cyc();
        off(0); off(1); cyc();

        // R10: reading the invalid word flags, on one and both ports
        cur_req = "R10";
        rd_at(0, 8'd9); cyc();
        rd_at(0, 8'd9); rd_at(1, 8'd9); cyc();

        // R11: partial write keeps the mark, full write clears it
        cur_req = "R11";
        setp(0, 1, 1, 8'd9, 32'h0BAD_0BAD, 32'hFFFF_0000, 4'b1100); off(1); cyc();
        rd_at(0, 8'd9); cyc();
        wr_full(1, 8'd9, 32'h600D_600D); off(0); cyc();
        rd_at(0, 8'd9); rd_at(1, 8'd9); cyc();

        // mixed traffic over a few words: R1 R3 R6 R7 R8 R9 R10 R11 all in play
        cur_req = "R8 R9 R10 R11 mix";
        for (int n = 0; n < 2000; n++) begin
            for (int p = 0; p < 2; p++) begin
                bit full = ($urandom_range(0, 1) == 1);
                setp(p, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                     8'($urandom_range(0, 7)), $urandom(),
                     full ? '0 : $urandom(), full ? 4'b0000 : 4'($urandom()));
            end
            cyc();
        end
        off(0); off(1); cyc();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule